// File: doc/BRIEF.md
# Segmented Converter Input Decoder

This block is the digital front end of a 10-bit current-steering digital-to-analog converter. A parallel input word is captured on the rising clock edge. The word is then split into two fields. The upper five bits are turned into a thermometer code that drives 31 unit segments of equal weight. The lower five bits pass straight through as controls for five binary-weighted switches. A second register stage holds the decoded pattern just ahead of the switch matrix, so that all switches change together.

Each switch has two enables: one steers its current to the primary output and the other to the complementary output. An active-high sleep input forces every enable low and freezes both register stages. Two numeric weight outputs report, in LSB units, how much current each output would carry. They are meant for checking.

The sleep handling is a two-state machine. In state ST_RUN the decoded pattern drives the switches. The transition T_SLEEP (sleep sampled high) moves it to ST_IDLE, where all enables are low. The transition T_WAKE (sleep sampled low) returns it to ST_RUN. Reset forces ST_RUN.

Top module: `sdec_top`

## Requirements
- R1: A synchronous active-high `rst` clears both register stages to code zero and selects ST_RUN. Afterwards `seg_p` and `bin_p` are all low, `seg_n` and `bin_n` are all high, `wt_p` is 0 and `wt_n` is 1023.
- R2: Outside sleep, a value on `din` shows up on the outputs after the second rising clock edge that samples it, and not after the first.
- R3: `seg_p` is 31 bits wide. Bit k-1 stands for unit segment k (k = 1..31) and is high exactly when `din[9:5]` is at least k, so segments fill from bit 0 upward with no gaps.
- R4: `bin_p[i]` equals `din[i]` for i = 0..4. Bit i carries a weight of 2^i LSB.
- R5: In ST_RUN, `seg_n` is the bitwise inverse of `seg_p` and `bin_n` is the bitwise inverse of `bin_p`.
- R6: `wt_p` equals 32 times the number of high bits in `seg_p`, plus the value of `bin_p`. That sum equals the held code. When the code steps from 31 to 32 (and likewise at every multiple of 32), all binary switches turn off and one more unit segment turns on.
- R7: In ST_RUN, `wt_p + wt_n` is 1023. Code 1023 gives `wt_p` = 1023. Code 0 gives `wt_n` = 1023. Code 512 gives 512 and 511.
- R8: After a clock edge that samples `sleep` high (state ST_IDLE), all four enable vectors are low and both weights are 0.
- R9: While `sleep` is high, changes on `din` do not reach the held data. On the first edge that samples `sleep` low, the outputs show the code held before sleep. The new `din` appears one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| sleep | input | 1 | Idle request, active high |
| din | input | 10 | Input code, bit 9 most significant |
| seg_p | output | 31 | Unit segment enables, primary output |
| seg_n | output | 31 | Unit segment enables, complementary output |
| bin_p | output | 5 | Binary switch enables, primary output |
| bin_n | output | 5 | Binary switch enables, complementary output |
| wt_p | output | 10 | Weight steered to the primary output, LSB units |
| wt_n | output | 10 | Weight steered to the complementary output, LSB units |

## Verification
The bench builds the block with its default split of five upper and five lower bits, which gives a 10-bit word and 31 segments. With that size every one of the 1024 codes can be swept exhaustively. The sweep reaches every 31-to-32 style carry boundary, both full-scale ends and mid-scale. The short word also makes the sleep hold and wake ordering cheap to pin down edge by edge.

// File: rtl/sdec_pkg.sv
package sdec_pkg;
    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_IDLE = 1'b1
    } drv_state_e;
endpackage

// File: rtl/sdec_stage.sv
module sdec_stage #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         hold,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (!hold) begin
            q <= d;
        end
    end
endmodule

// File: rtl/sdec_thermo.sv
module sdec_thermo #(
    parameter int HI_W = 5,
    localparam int SEGS = (1 << HI_W) - 1
) (
    input  logic [HI_W-1:0] code,
    output logic [SEGS-1:0] therm
);
    for (genvar k = 0; k < SEGS; k++) begin : g_seg
        localparam logic [HI_W-1:0] LEVEL = HI_W'(k + 1);
        assign therm[k] = (code >= LEVEL);
    end
endmodule

// File: rtl/sdec_drive.sv
module sdec_drive
    import sdec_pkg::*;
#(
    parameter int SEGS = 31,
    parameter int LO_W = 5
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            sleep,
    input  logic [SEGS-1:0] seg_q,
    input  logic [LO_W-1:0] bin_q,
    output logic [SEGS-1:0] seg_p,
    output logic [SEGS-1:0] seg_n,
    output logic [LO_W-1:0] bin_p,
    output logic [LO_W-1:0] bin_n
);
    drv_state_e state_q;
    drv_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:  if (sleep)  state_d = ST_IDLE;   // T_SLEEP
            ST_IDLE: if (!sleep) state_d = ST_RUN;    // T_WAKE
            default: state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        seg_p = '0;
        seg_n = '0;
        bin_p = '0;
        bin_n = '0;
        unique case (state_q)
            ST_RUN: begin
                seg_p = seg_q;
                seg_n = ~seg_q;
                bin_p = bin_q;
                bin_n = ~bin_q;
            end
            ST_IDLE: begin
                seg_p = '0;
                seg_n = '0;
                bin_p = '0;
                bin_n = '0;
            end
            default: begin
                seg_p = '0;
                seg_n = '0;
                bin_p = '0;
                bin_n = '0;
            end
        endcase
    end
endmodule

// File: rtl/sdec_weight.sv
module sdec_weight #(
    parameter int HI_W = 5,
    parameter int LO_W = 5,
    localparam int SEGS = (1 << HI_W) - 1
) (
    input  logic [SEGS-1:0]      seg,
    input  logic [LO_W-1:0]      bin,
    output logic [HI_W+LO_W-1:0] wt
);
    logic [HI_W-1:0] units;

    always_comb begin
        units = '0;
        for (int i = 0; i < SEGS; i++) begin
            units = units + HI_W'(seg[i]);
        end
    end

    assign wt = {units, bin};
endmodule

// File: rtl/sdec_top.sv
module sdec_top #(
    parameter int HI_W = 5,
    parameter int LO_W = 5,
    localparam int WORD_W = HI_W + LO_W,
    localparam int SEGS = (1 << HI_W) - 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sleep,
    input  logic [WORD_W-1:0] din,
    output logic [SEGS-1:0]   seg_p,
    output logic [SEGS-1:0]   seg_n,
    output logic [LO_W-1:0]   bin_p,
    output logic [LO_W-1:0]   bin_n,
    output logic [WORD_W-1:0] wt_p,
    output logic [WORD_W-1:0] wt_n
);
    localparam int DEC_W = SEGS + LO_W;

    logic [WORD_W-1:0] word_q;
    logic [SEGS-1:0]   therm_d;
    logic [DEC_W-1:0]  dec_q;

    sdec_stage #(.W(WORD_W)) u_in_stage (
        .clk  (clk),
        .rst  (rst),
        .hold (sleep),
        .d    (din),
        .q    (word_q)
    );

    sdec_thermo #(.HI_W(HI_W)) u_thermo (
        .code  (word_q[WORD_W-1:LO_W]),
        .therm (therm_d)
    );

    sdec_stage #(.W(DEC_W)) u_sw_stage (
        .clk  (clk),
        .rst  (rst),
        .hold (sleep),
        .d    ({therm_d, word_q[LO_W-1:0]}),
        .q    (dec_q)
    );

    sdec_drive #(.SEGS(SEGS), .LO_W(LO_W)) u_drive (
        .clk   (clk),
        .rst   (rst),
        .sleep (sleep),
        .seg_q (dec_q[DEC_W-1:LO_W]),
        .bin_q (dec_q[LO_W-1:0]),
        .seg_p (seg_p),
        .seg_n (seg_n),
        .bin_p (bin_p),
        .bin_n (bin_n)
    );

    sdec_weight #(.HI_W(HI_W), .LO_W(LO_W)) u_wt_p (
        .seg (seg_p),
        .bin (bin_p),
        .wt  (wt_p)
    );

    sdec_weight #(.HI_W(HI_W), .LO_W(LO_W)) u_wt_n (
        .seg (seg_n),
        .bin (bin_n),
        .wt  (wt_n)
    );
endmodule

// File: rtl/sdec_checker.sv
module sdec_checker #(
    parameter int HI_W = 5,
    parameter int LO_W = 5,
    localparam int WORD_W = HI_W + LO_W,
    localparam int SEGS = (1 << HI_W) - 1
) (
    input logic              clk,
    input logic              rst,
    input logic              sleep,
    input logic [WORD_W-1:0] din,
    input logic [SEGS-1:0]   seg_p,
    input logic [SEGS-1:0]   seg_n,
    input logic [LO_W-1:0]   bin_p,
    input logic [LO_W-1:0]   bin_n,
    input logic [WORD_W-1:0] wt_p,
    input logic [WORD_W-1:0] wt_n
);
    localparam logic [WORD_W:0] FULL = (WORD_W + 1)'((1 << WORD_W) - 1);

    logic [SEGS-1:0] seg_inc;
    assign seg_inc = seg_p + SEGS'(1);

    a_r3_thermo_fill: assert property (@(posedge clk) disable iff (rst)
        (seg_p & seg_inc) == '0);

    a_r5_complement: assert property (@(posedge clk) disable iff (rst)
        (!$past(sleep) && !$past(rst)) |-> ({seg_n, bin_n} == ~{seg_p, bin_p}));

    a_r7_weight_sum: assert property (@(posedge clk) disable iff (rst)
        (!$past(sleep) && !$past(rst)) |-> (({1'b0, wt_p} + {1'b0, wt_n}) == FULL));

    a_r8_sleep_idle: assert property (@(posedge clk) disable iff (rst)
        ($past(sleep) && !$past(rst)) |->
            (seg_p == '0 && seg_n == '0 && bin_p == '0 && bin_n == '0));

    a_r2_latency: assert property (@(posedge clk) disable iff (rst)
        (!$past(sleep) && !$past(sleep, 2) && !$past(rst) && !$past(rst, 2))
            |-> (wt_p == $past(din, 2)));
endmodule

bind sdec_top sdec_checker #(.HI_W(HI_W), .LO_W(LO_W)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .sleep (sleep),
    .din   (din),
    .seg_p (seg_p),
    .seg_n (seg_n),
    .bin_p (bin_p),
    .bin_n (bin_n),
    .wt_p  (wt_p),
    .wt_n  (wt_n)
);

// File: tb/sim_sdec_top.sv
module sim_sdec_top;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 12;
    // {code, expected wt_p, expected active segment count}
    localparam logic [24:0] VEC [NVEC] = '{
        {10'd0,    10'd0,    5'd0},
        {10'd1,    10'd1,    5'd0},
        {10'd31,   10'd31,   5'd0},
        {10'd32,   10'd32,   5'd1},
        {10'd63,   10'd63,   5'd1},
        {10'd64,   10'd64,   5'd2},
        {10'd341,  10'd341,  5'd10},
        {10'd511,  10'd511,  5'd15},
        {10'd512,  10'd512,  5'd16},
        {10'd682,  10'd682,  5'd21},
        {10'd992,  10'd992,  5'd31},
        {10'd1023, 10'd1023, 5'd31}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sleep = 1'b0;
    logic [9:0]  din = '0;
    logic [30:0] seg_p, seg_n;
    logic [4:0]  bin_p, bin_n;
    logic [9:0]  wt_p, wt_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sdec_top u0 (
        .clk(clk), .rst(rst), .sleep(sleep), .din(din),
        .seg_p(seg_p), .seg_n(seg_n), .bin_p(bin_p), .bin_n(bin_n),
        .wt_p(wt_p), .wt_n(wt_n)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [30:0] therm_of(input int n);
        logic [30:0] t = '0;
        for (int k = 0; k < n; k++) t[k] = 1'b1;
        return t;
    endfunction

    task automatic check_code(input int code);
        int n = code / 32;
        chk(seg_p == therm_of(n), "R3 thermometer", int'(seg_p), int'(therm_of(n)));
        chk(bin_p == 5'(code % 32), "R4 binary", int'(bin_p), code % 32);
        chk(seg_n == ~seg_p && bin_n == ~bin_p, "R5 complement",
            int'({seg_n, bin_n}), int'(~{seg_p, bin_p}));
        chk(wt_p == 10'(code), "R6 primary weight", int'(wt_p), code);
        chk(int'(wt_p) + int'(wt_n) == 1023, "R7 sum", int'(wt_p) + int'(wt_n), 1023);
    endtask

    task automatic apply(input int code);
        @(negedge clk) din = 10'(code);
        @(posedge clk);
        @(posedge clk);
        #1;
    endtask

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk(wt_p == 0 && wt_n == 1023, "R1 reset weights", int'(wt_n), 1023);
        chk(seg_n == '1 && bin_n == '1 && seg_p == '0, "R1 reset enables",
            int'(seg_n), int'(31'h7fffffff));
        @(negedge clk) rst = 1'b0;

        // table walk
        for (int i = 0; i < NVEC; i++) begin
            apply(int'(VEC[i][24:15]));
            chk(wt_p == VEC[i][14:5], "R6 table weight", int'(wt_p), int'(VEC[i][14:5]));
            chk($countones(seg_p) == int'(VEC[i][4:0]), "R3 table count",
                $countones(seg_p), int'(VEC[i][4:0]));
            check_code(int'(VEC[i][24:15]));
        end

        // R7 end points and mid-scale
        apply(1023);
        chk(wt_p == 1023 && wt_n == 0, "R7 full scale primary", int'(wt_p), 1023);
        apply(0);
        chk(wt_n == 1023 && wt_p == 0, "R7 full scale complement", int'(wt_n), 1023);
        apply(512);
        chk(wt_p == 512 && wt_n == 511, "R7 mid scale", int'(wt_n), 511);

        // R6 carry boundary 31 -> 32
        apply(31);
        chk(bin_p == 5'h1f && seg_p == '0, "R6 before carry", int'(bin_p), 31);
        apply(32);
        chk(bin_p == 5'h00 && seg_p == 31'h1, "R6 after carry", int'(seg_p), 1);

        // R2 latency
        apply(100);
        @(negedge clk) din = 10'd900;
        @(posedge clk); #1;
        chk(wt_p == 100, "R2 one edge", int'(wt_p), 100);
        @(posedge clk); #1;
        chk(wt_p == 900, "R2 two edges", int'(wt_p), 900);

        // R8 / R9 sleep
        apply(777);
        @(negedge clk) sleep = 1'b1;
        @(posedge clk); #1;
        chk(seg_p == '0 && seg_n == '0 && bin_p == '0 && bin_n == '0, "R8 idle enables",
            int'({seg_p, bin_p}) | int'({seg_n, bin_n}), 0);
        chk(wt_p == 0 && wt_n == 0, "R8 idle weights", int'(wt_p) + int'(wt_n), 0);
        @(negedge clk) din = 10'd5;
        repeat (3) @(posedge clk);
        #1;
        chk(wt_p == 0 && wt_n == 0, "R8 idle held", int'(wt_p) + int'(wt_n), 0);
        @(negedge clk) sleep = 1'b0;
        @(posedge clk); #1;
        chk(wt_p == 777, "R9 resume with held code", int'(wt_p), 777);
        chk(wt_n == 246, "R9 resume complement", int'(wt_n), 246);
        @(posedge clk); #1;
        chk(wt_p == 5, "R9 new code one edge later", int'(wt_p), 5);

        // exhaustive sweep
        for (int c = 0; c < 1024; c++) begin
            apply(c);
            check_code(c);
        end

        // R1 reset during sleep clears and returns to run
        apply(600);
        @(negedge clk) begin rst = 1'b1; sleep = 1'b1; end
        @(posedge clk); #1;
        chk(wt_p == 0 && wt_n == 1023, "R1 reset over sleep", int'(wt_n), 1023);
        @(negedge clk) begin rst = 1'b0; sleep = 1'b0; din = 10'd0; end
        @(posedge clk); #1;
        chk(wt_p == 0 && seg_n == '1, "R1 held zero after reset", int'(wt_p), 0);

        done = 1'b1;
        finish_run();
    end
endmodule